// File: doc/BRIEF.md
# Serial-Loaded Break-Before-Make Channel Selector

This block is the digital controller of an eight-way switch array. It takes a control word on a three-wire serial port made up of a shift clock, a frame strobe and a data line. While the strobe is high, each rising edge of the shift clock moves one bit into a four-stage shift register. The last stage of that register is driven out on a serial output, so the output of one device can feed the data input of the next. A single frame of 4N bits then loads N chained devices, and the first nibble sent ends up in the device farthest from the port.

All three port lines are sampled by a free-running system clock through a synchroniser. A falling strobe commits the word held in the register. The block then runs a break-before-make sequence. The channel that was on stays on for `T_OFF` system cycles and then goes off. The enable bus stays all-zero until `T_ON` cycles after the commit, and then the newly decoded channel is switched on. The result is a one-hot enable bus, or an all-zero bus when the word disables the array.

Top module: `smux_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sw_en` is all-zero, `dout` is 0 and every shift stage is cleared.
- R2: While `cs` is high, each rising `sclk` edge shifts `din` into the register, most significant bit first. A complete word is {EN, B2, B1, B0}, with EN in bit 3 and B0 in bit 0.
- R3: `dout` is the register's bit 3. A bit shifted in appears on `dout` after the fourth rising `sclk` edge.
- R4: While `cs` is low, `sclk` and `din` have no effect. `dout` and the stored word are unchanged, and the stored word can be committed again by a later strobe with no shifting.
- R5: A committed word with EN=1 turns on exactly the channel whose index is {B2,B1,B0}. Bit i of `sw_en` is channel i, so 000 selects bit 0 and 111 selects bit 7.
- R6: A committed word with EN=0 leaves every bit of `sw_en` at 0, whatever B2..B0 are.
- R7: Let E be the system-clock edge on which a `cs` fall is detected, which is `SYNC_STAGES`+1 edges after the input changes. The previous enable pattern holds until edge E+`T_OFF`, where it becomes zero. The new pattern appears at edge E+`T_ON`.
- R8: `sw_en` never has more than one bit set. It never moves straight from one nonzero value to a different nonzero value, and a nonzero value appears only at the end of a commit sequence.
- R9: Once the sequence is complete, `sw_en` stays constant until the next detected `cs` fall.
- R10: When two devices are chained (dout of the first into din of the second) and loaded with one 8-bit frame, the second device decodes the first nibble sent and the first device decodes the second nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial shift clock, sampled by `clk` |
| cs | input | 1 | Frame strobe: high to shift, falling edge commits |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out (last shift stage) for chaining |
| sw_en | output | CH_N | One-hot switch-enable bus, bit i = channel i |

## Verification
The bench builds two chained instances with `SYNC_STAGES`=2, `T_OFF`=3 and `T_ON`=7, so a commit is detected three edges after the strobe falls. These values leave a four-cycle all-zero gap between the old channel going off and the new one coming on, long enough to measure to the exact edge and short enough to check on every frame. Each instance has eight channels, so every channel index and the disable code can be reached in an 8-bit frame. The shift clock is held for several system cycles in each phase, so the chained data line always settles before the next device samples it.

// File: rtl/smux_pkg.sv
package smux_pkg;

   // Phases of the commit sequence
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,   // pattern stable
      SQ_HOLD = 2'd1,   // old pattern still driven, waiting for off time
      SQ_GAP  = 2'd2    // all switches open, waiting for on time
   } sq_state_t;

   // Width of a control word for a given channel count
   function automatic int word_width(input int ch_n);
      return $clog2(ch_n) + 1;
   endfunction

endpackage

// File: rtl/smux_sync.sv
module smux_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) q_prev <= '0;
      else        q_prev <= q;
   end

endmodule

// File: rtl/smux_shift.sv
module smux_shift #(
   parameter int WW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          bit_in,
   output logic [WW-1:0] word,
   output logic          bit_out
);

   logic [WW-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        stage_q <= '0;
      else if (shift_en) stage_q <= {stage_q[WW-2:0], bit_in};
   end

   assign word    = stage_q;
   assign bit_out = stage_q[WW-1];

endmodule

// File: rtl/smux_dec.sv
module smux_dec #(
   parameter int CH_N  = 8,
   localparam int SEL_W = $clog2(CH_N),
   localparam int WW    = SEL_W + 1
) (
   input  logic [WW-1:0]   word,
   output logic [CH_N-1:0] onehot
);

   logic              enable;
   logic [SEL_W-1:0]  index;

   assign enable = word[WW-1];
   assign index  = word[SEL_W-1:0];

   generate
      for (genvar c = 0; c < CH_N; c++) begin : g_ch
         assign onehot[c] = enable && (index == SEL_W'(c));
      end
   endgenerate

endmodule

// File: rtl/smux_seq.sv
module smux_seq
   import smux_pkg::*;
#(
   parameter int CH_N  = 8,
   parameter int T_OFF = 3,
   parameter int T_ON  = 7,
   localparam int CW   = $clog2(T_ON + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            commit,
   input  logic [CH_N-1:0] target,
   output logic [CH_N-1:0] en_out,
   output logic            busy
);

   sq_state_t         st_q;
   logic [CW-1:0]     cnt_q;
   logic [CH_N-1:0]   pend_q;
   logic [CH_N-1:0]   en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         cnt_q  <= '0;
         pend_q <= '0;
         en_q   <= '0;
      end else if (commit) begin
         pend_q <= target;
         cnt_q  <= CW'(1);
         if (T_OFF == 0) begin
            en_q <= '0;
            st_q <= SQ_GAP;
         end else begin
            st_q <= SQ_HOLD;
         end
      end else begin
         case (st_q)
            SQ_HOLD: begin
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(T_OFF)) begin
                  en_q <= '0;
                  st_q <= SQ_GAP;
               end
            end
            SQ_GAP: begin
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(T_ON)) begin
                  en_q <= pend_q;
                  st_q <= SQ_IDLE;
               end
            end
            default: cnt_q <= '0;
         endcase
      end
   end

   assign en_out = en_q;
   assign busy   = (st_q != SQ_IDLE);

endmodule

// File: rtl/smux_ctrl.sv
module smux_ctrl #(
   parameter int CH_N        = 8,
   parameter int SYNC_STAGES = 2,
   parameter int T_OFF       = 3,
   parameter int T_ON        = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sclk,
   input  logic            cs,
   input  logic            din,
   output logic            dout,
   output logic [CH_N-1:0] sw_en
);

   localparam int WW = smux_pkg::word_width(CH_N);

   generate
      if (CH_N < 2 || (1 << $clog2(CH_N)) != CH_N) begin : g_bad_ch
         $error("smux_ctrl: CH_N must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("smux_ctrl: SYNC_STAGES must be at least 1");
      end
      if (T_ON <= T_OFF || T_OFF < 0) begin : g_bad_time
         $error("smux_ctrl: need 0 <= T_OFF < T_ON");
      end
   endgenerate

   // Synchronised port lines: bit 2 = sclk, bit 1 = cs, bit 0 = din
   logic [2:0] port_s, port_p;

   smux_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      ({sclk, cs, din}),
      .q      (port_s),
      .q_prev (port_p)
   );

   logic sclk_rise, cs_s, cs_fall, din_s;
   assign sclk_rise = port_s[2] & ~port_p[2];
   assign cs_s      = port_s[1];
   assign cs_fall   = ~port_s[1] & port_p[1];
   assign din_s     = port_s[0];

   logic [WW-1:0]   word;
   logic [CH_N-1:0] target;
   logic            busy;

   smux_shift #(.WW(WW)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sclk_rise & cs_s),
      .bit_in   (din_s),
      .word     (word),
      .bit_out  (dout)
   );

   smux_dec #(.CH_N(CH_N)) u_dec (
      .word   (word),
      .onehot (target)
   );

   smux_seq #(.CH_N(CH_N), .T_OFF(T_OFF), .T_ON(T_ON)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (cs_fall),
      .target (target),
      .en_out (sw_en),
      .busy   (busy)
   );

endmodule

// File: rtl/smux_ctrl_chk.sv
module smux_ctrl_chk #(
   parameter int CH_N = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_s,
   input logic            busy,
   input logic            dout,
   input logic [CH_N-1:0] sw_en
);

   // R1: reset forces the switches open
   assert_reset_open_R1: assert property (@(posedge clk)
      !rst_n |=> (sw_en == '0 && !dout));

   // R4: with the strobe low the serial output cannot move
   assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> $stable(dout));

   // R8: never more than one switch closed
   assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_en));

   // R8: no direct hop from one closed switch to another
   assert_break_before_make_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en != '0 && $past(sw_en) != '0) |-> sw_en == $past(sw_en));

   // R9: the pattern changes only while a commit sequence runs
   assert_stable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> $stable(sw_en));

endmodule

bind smux_ctrl smux_ctrl_chk #(.CH_N(CH_N)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_s  (cs_s),
   .busy  (busy),
   .dout  (dout),
   .sw_en (sw_en)
);

// File: tb/smux_ctrl_bench.sv
module smux_ctrl_bench;

   localparam int CH_N  = 8;
   localparam int SYNC  = 2;
   localparam int T_OFF = 3;
   localparam int T_ON  = 7;
   localparam int LAT   = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs = 1'b0, din = 1'b0;
   logic dout_a, dout_b;
   logic [CH_N-1:0] sw_a, sw_b;

   always #2 clk = ~clk;   // 250 MHz

   // Device A is nearest the port, B is chained after it
   smux_ctrl #(.CH_N(CH_N), .SYNC_STAGES(SYNC), .T_OFF(T_OFF), .T_ON(T_ON)) u_smux_ctrl (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .din(din),
      .dout(dout_a), .sw_en(sw_a));

   smux_ctrl #(.CH_N(CH_N), .SYNC_STAGES(SYNC), .T_OFF(T_OFF), .T_ON(T_ON)) u_smux_far (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .din(dout_a),
      .dout(dout_b), .sw_en(sw_b));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // {word for B, word for A, expected B, expected A}
   localparam logic [23:0] VEC [6] = '{
      {4'hD, 4'h8, 8'h20, 8'h01},
      {4'hF, 4'h9, 8'h80, 8'h02},
      {4'h3, 4'hE, 8'h00, 8'h40},
      {4'hA, 4'h0, 8'h04, 8'h00},
      {4'hB, 4'hC, 8'h08, 8'h10},
      {4'hB, 4'hC, 8'h08, 8'h10}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); din = b;
      wait_clk(2); sclk = 1'b1;
      wait_clk(4); sclk = 1'b0;
      wait_clk(4);
   endtask

   // Drop cs and watch both devices through the commit sequence (R7, R8)
   task automatic commit_and_watch(input logic [7:0] exp_a, input logic [7:0] exp_b);
      logic [7:0] prev_a, prev_b;
      int tz_a, tn_a, tz_b, tn_b, bad;
      prev_a = sw_a; prev_b = sw_b;
      tz_a = -1; tn_a = -1; tz_b = -1; tn_b = -1; bad = 0;
      @(negedge clk); cs = 1'b0;
      for (int n = 1; n <= LAT + T_ON + 4; n++) begin
         @(posedge clk); #1;
         if (tz_a < 0 && sw_a == 8'h00) tz_a = n;
         if (tz_b < 0 && sw_b == 8'h00) tz_b = n;
         if (tn_a < 0 && n > LAT + T_OFF && sw_a == exp_a) tn_a = n;
         if (tn_b < 0 && n > LAT + T_OFF && sw_b == exp_b) tn_b = n;
         if ($countones(sw_a) > 1 || $countones(sw_b) > 1) bad++;
         if (sw_a != 0 && sw_a != prev_a && sw_a != exp_a) bad++;
         if (sw_b != 0 && sw_b != prev_b && sw_b != exp_b) bad++;
      end
      check(sw_a == exp_a, exp_a == 0 ? "R6 device A" : "R5 device A", sw_a, exp_a);
      check(sw_b == exp_b, exp_b == 0 ? "R6 device B (R10)" : "R5 device B (R10)", sw_b, exp_b);
      check(bad == 0, "R8 one-hot / no direct hop", bad, 0);
      if (prev_a != 0) check(tz_a == LAT + T_OFF, "R7 off time A", tz_a, LAT + T_OFF);
      if (prev_b != 0) check(tz_b == LAT + T_OFF, "R7 off time B", tz_b, LAT + T_OFF);
      if (exp_a != 0) check(tn_a == LAT + T_ON, "R7 on time A", tn_a, LAT + T_ON);
      if (exp_b != 0) check(tn_b == LAT + T_ON, "R7 on time B", tn_b, LAT + T_ON);
   endtask

   task automatic send_frame(input logic [3:0] wb, input logic [3:0] wa,
                             input logic [7:0] exp_a, input logic [7:0] exp_b);
      @(negedge clk); cs = 1'b1;
      wait_clk(2);
      for (int i = 3; i >= 0; i--) send_bit(wb[i]);
      // R3: first bit sent shows on A's output after four shifts
      check(dout_a == wb[3], "R3 first bit after fourth edge", dout_a, wb[3]);
      for (int i = 3; i >= 0; i--) send_bit(wa[i]);
      // R2/R10: register contents visible on the chain outputs
      check(dout_a == wa[3], "R2 A holds second nibble", dout_a, wa[3]);
      check(dout_b == wb[3], "R10 B holds first nibble", dout_b, wb[3]);
      commit_and_watch(exp_a, exp_b);
   endtask

   initial begin
      wait_clk(5);
      // R1: reset state
      check(sw_a == 0 && sw_b == 0, "R1 enables off in reset", {sw_b, sw_a}, 0);
      check(dout_a == 0 && dout_b == 0, "R1 serial out low", {dout_b, dout_a}, 0);
      @(negedge clk); rst_n = 1'b1;
      wait_clk(3);
      check(sw_a == 0 && sw_b == 0, "R1 enables off after reset", {sw_b, sw_a}, 0);

      foreach (VEC[k]) begin
         send_frame(VEC[k][23:20], VEC[k][19:16], VEC[k][7:0], VEC[k][15:8]);
         // R9: pattern stays until next strobe fall
         wait_clk(20);
         check(sw_a == VEC[k][7:0] && sw_b == VEC[k][15:8], "R9 pattern held",
               {sw_b, sw_a}, {VEC[k][15:8], VEC[k][7:0]});
      end

      // R4: clocking with cs low is ignored
      for (int i = 0; i < 6; i++) send_bit(i[0]);
      check(dout_a == 1'b1 && dout_b == 1'b1, "R4 outputs unchanged with cs low",
            {dout_b, dout_a}, 2'b11);
      check(sw_a == 8'h10 && sw_b == 8'h08, "R4 enables unchanged", {sw_b, sw_a}, 16'h0810);
      // R4: recommit stored words without shifting
      @(negedge clk); cs = 1'b1;
      wait_clk(4);
      commit_and_watch(8'h10, 8'h08);

      // R6 with nonzero index, then R5 extremes
      send_frame(4'h7, 4'h5, 8'h00, 8'h00);
      send_frame(4'h8, 4'hF, 8'h80, 8'h01);

      // R1: reset mid-operation
      @(negedge clk); rst_n = 1'b0;
      wait_clk(2);
      check(sw_a == 0 && sw_b == 0 && dout_a == 0 && dout_b == 0,
            "R1 reset clears", {dout_b, dout_a, sw_b, sw_a}, 0);
      @(negedge clk); rst_n = 1'b1;
      wait_clk(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule